// File: doc/BRIEF.md
# Multichannel ADC serial host controller

This block is the host end of the serial link to a 10-bit successive-approximation converter with 14 selectable inputs. It produces the chip select and the serial clock, shifts a 4-bit channel number out to the converter, and shifts in the converter's reply during the same frame. The reply always belongs to the conversion requested one frame earlier. The block therefore tags every result with the channel that was addressed in the previous frame. The first reply after a reset, a mode change or a resynchronisation reflects no request, so the block drops it.

Two framing styles are supported. In released mode, chip select goes high after every frame, and each frame is started by a strobe with a runtime length of 11 to 16 clocks. In continuous mode, a strobe starts the first frame. Chip select then stays low and every later frame is exactly 16 clocks long, starting when end-of-conversion rises. If end-of-conversion does not rise within a bounded wait, the host toggles chip select to bring the converter back into step. The serial clock is the system clock divided by a parameter.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is asserted, and afterwards until a frame starts, cs_no is 1 and sclk_o, addr_o and result_valid_o are 0.
- R2: In released mode (cont_mode_i = 0), a start_i pulse while idle drops cs_no and issues len_i rising clock edges, then raises cs_no. A len_i below 11 counts as 11 and a len_i above 16 counts as 16. sclk_o is low whenever cs_no is high.
- R3: In continuous mode (cont_mode_i = 1), every frame has exactly 16 rising edges, and cs_no stays low between frames. Every frame after the first starts only after eoc_i has risen.
- R4: chan_i is captured at frame start and is driven on addr_o MSB first. Channel bit 3 is valid at rising edge 1, bit 2 at edge 2, bit 1 at edge 3 and bit 0 at edge 4.
- R5: sdo_i is sampled on the first 10 rising edges of a frame, and the first sample becomes result bit 9. Later edges do not change the result. result_valid_o pulses for one cycle at frame end, in the cycle where the last falling edge or the chip-select release occurs, and at no other time.
- R6: result_chan_o carries the channel addressed in the frame before the one that delivered result_o.
- R7: No result_valid_o pulse occurs for the first frame after reset, for the first frame whose mode differs from the mode of the previous frame, or for the first frame after a resynchronisation.
- R8: In continuous mode, if eoc_i does not rise within TIMEOUT_CYC system cycles after a frame ends, cs_no goes high for one half clock period. A new frame then starts on its own.
- R9: Lowering cont_mode_i while waiting for eoc_i raises cs_no, and the block stays idle until the next start_i.
- R10: start_i has no effect while a frame is in progress.
- R11: Each high phase of sclk_o lasts HALF_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a released frame, or for the first continuous frame |
| chan_i | input | 4 | Channel to request in the next frame |
| cont_mode_i | input | 1 | 1 = chip select held low and frames paced by end-of-conversion; 0 = chip select released after each frame |
| len_i | input | 5 | Frame length in clocks for released mode, clamped to 11..16 |
| eoc_i | input | 1 | End-of-conversion from the converter, asynchronous |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| addr_o | output | 1 | Serial channel address to the converter |
| result_o | output | 10 | Last received conversion result |
| result_chan_o | output | 4 | Channel that result_o belongs to |
| result_valid_o | output | 1 | One-cycle strobe marking a new valid result |

## Verification
A bus model of the converter answers each frame with a value that encodes the address it actually captured plus a sequence number. A wrong channel, a bit slip or a missing previous-frame offset therefore each show up as a distinct mismatch in result_o or result_chan_o. Released frames run at fixed lengths, at clamped lengths (5 and 20) and at random lengths and channels, which separates length handling from data capture. Continuous frames run with changing channels, with one conversion whose end-of-conversion never comes (this exercises the timeout and the discarded frame that follows), and with an exit back to released mode, which separates mode-change invalidation from reset invalidation.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 10;
  localparam int LEN_W   = 5;
  localparam int MIN_LEN = 11;
  localparam int MAX_LEN = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_GAP, ST_WAIT, ST_RESYNC
  } host_st_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    logic [LEN_W-1:0] r;
    r = l;
    if (l < LEN_W'(MIN_LEN)) r = LEN_W'(MIN_LEN);
    else if (l > LEN_W'(MAX_LEN)) r = LEN_W'(MAX_LEN);
    return r;
  endfunction
endpackage

// File: rtl/adc_host_tick.sv
module adc_host_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF_DIV - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      a_r11_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/adc_host_sync.sv
module adc_host_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;
endmodule

// File: rtl/adc_host_shift.sv
module adc_host_shift #(
  parameter int AW = 4,
  parameter int DW = 10,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sdo_i,
  output logic          addr_bit_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] rise_cnt_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (rise_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CW'(DW)) data_q <= {data_q[DW-2:0], sdo_i};
      end
      // next address bit goes out on the falling edge
      if (fall_i) addr_q <= {addr_q[AW-2:0], 1'b0};
    end
  end

  assign addr_bit_o = addr_q[AW-1];
  assign data_o     = data_q;
  assign rise_cnt_o = cnt_q;

  a_r5_sample_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !load_i && cnt_q >= CW'(DW)) |=> $stable(data_q));
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              cont_mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              eoc_i,
  input  logic              sdo_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              addr_o,
  output logic [DATA_W-1:0] result_o,
  output logic [ADDR_W-1:0] result_chan_o,
  output logic              result_valid_o
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  host_st_e          state_q, state_d;
  logic              tick, tick_en, eoc_rise;
  logic              load, load_mode, rise_ev, fall_ev, end_ev, resync_go;
  logic [LEN_W-1:0]  frame_len_q, rise_cnt;
  logic              cur_mode_q, last_mode_q, prev_valid_q;
  logic [ADDR_W-1:0] prev_chan_q, chan_q;
  logic [TO_W-1:0]   to_cnt_q;
  logic [DATA_W-1:0] data_w;
  logic              addr_bit;

  assign tick_en = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH) ||
                   (state_q == ST_GAP) || (state_q == ST_RESYNC);

  adc_host_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick_en), .tick_o(tick)
  );

  adc_host_sync u_eoc_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(eoc_i), .rise_o(eoc_rise)
  );

  assign load = (state_q == ST_IDLE && start_i) ||
                (state_q == ST_WAIT && cont_mode_i && eoc_rise) ||
                (state_q == ST_RESYNC && tick);
  assign load_mode = (state_q == ST_IDLE) ? cont_mode_i : 1'b1;
  assign rise_ev   = tick && (state_q == ST_SETUP || state_q == ST_LOW);
  assign end_ev    = tick && (state_q == ST_HIGH) && (rise_cnt == frame_len_q);
  assign fall_ev   = tick && (state_q == ST_HIGH) && !end_ev;
  assign resync_go = (state_q == ST_WAIT) && cont_mode_i && !eoc_rise &&
                     (to_cnt_q == TO_W'(TIMEOUT_CYC - 1));

  adc_host_shift #(.AW(ADDR_W), .DW(DATA_W), .CW(LEN_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .addr_i(chan_i),
    .rise_i(rise_ev), .fall_i(fall_ev), .sdo_i(sdo_i),
    .addr_bit_o(addr_bit), .data_o(data_w), .rise_cnt_o(rise_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETUP;
      ST_SETUP:  if (tick) state_d = ST_HIGH;
      ST_LOW:    if (tick) state_d = ST_HIGH;
      ST_HIGH:   if (end_ev) state_d = cur_mode_q ? ST_WAIT : ST_GAP;
                 else if (tick) state_d = ST_LOW;
      ST_GAP:    if (tick) state_d = ST_IDLE;
      ST_WAIT:   if (!cont_mode_i) state_d = ST_GAP;
                 else if (eoc_rise) state_d = ST_SETUP;
                 else if (resync_go) state_d = ST_RESYNC;
      ST_RESYNC: if (tick) state_d = ST_SETUP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      frame_len_q    <= LEN_W'(MAX_LEN);
      cur_mode_q     <= 1'b0;
      last_mode_q    <= 1'b0;
      prev_valid_q   <= 1'b0;
      prev_chan_q    <= '0;
      chan_q         <= '0;
      to_cnt_q       <= '0;
      result_o       <= '0;
      result_chan_o  <= '0;
      result_valid_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      result_valid_o <= 1'b0;
      to_cnt_q       <= (state_q == ST_WAIT) ? to_cnt_q + 1'b1 : '0;
      if (load) begin
        chan_q      <= chan_i;
        cur_mode_q  <= load_mode;
        frame_len_q <= load_mode ? LEN_W'(MAX_LEN) : clamp_len(len_i);
        last_mode_q <= load_mode;
        if (load_mode != last_mode_q) prev_valid_q <= 1'b0;
      end
      if (resync_go) prev_valid_q <= 1'b0;
      if (end_ev) begin
        result_valid_o <= prev_valid_q;
        result_o       <= data_w;
        result_chan_o  <= prev_chan_q;
        prev_chan_q    <= chan_q;
        prev_valid_q   <= 1'b1;
      end
    end
  end

  assign cs_no  = (state_q == ST_IDLE) || (state_q == ST_GAP) || (state_q == ST_RESYNC);
  assign sclk_o = (state_q == ST_HIGH);
  assign addr_o = !cs_no && addr_bit;

  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (frame_len_q >= LEN_W'(MIN_LEN) && frame_len_q <= LEN_W'(MAX_LEN)));
  a_r2_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> rise_cnt <= frame_len_q);
  a_r3_cont_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && cur_mode_q) |-> frame_len_q == LEN_W'(MAX_LEN));
  a_r4_addr_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(addr_o));
  a_r5_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  a_r8_resync_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RESYNC) |-> $past(to_cnt_q) == TO_W'(TIMEOUT_CYC - 1));
  a_r9_exit_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !cont_mode_i) |=> cs_no);
endmodule

// File: tb/adc_serial_host_bench.sv
module adc_serial_host_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int HALF_DIV    = 4;
  localparam int TIMEOUT_CYC = 200;
  localparam int CONV        = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] chan = '0;
  logic       cont = 1'b0;
  logic [4:0] len = 5'd16;
  logic       eoc = 1'b1;
  logic       sdo = 1'b0;
  logic       cs_n, sclk, addr;
  logic [9:0] res;
  logic [3:0] res_chan;
  logic       res_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_host #(.HALF_DIV(HALF_DIV), .TIMEOUT_CYC(TIMEOUT_CYC)) u_adc_serial_host (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .cont_mode_i(cont),
    .len_i(len), .eoc_i(eoc), .sdo_i(sdo), .cs_no(cs_n), .sclk_o(sclk), .addr_o(addr),
    .result_o(res), .result_chan_o(res_chan), .result_valid_o(res_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len_f(input int l);
    if (l < 11) return 11;
    if (l > 16) return 16;
    return l;
  endfunction

  // converter bus model
  logic       cs_p = 1'b1, sc_p = 1'b0;
  logic [3:0] cap_addr = '0, frame_chan = '0, stored_chan = '0, exp_chan = '0;
  logic [9:0] out_sr = '0, stored_val = '0, exp_data = '0;
  logic [5:0] seq = '0;
  bit in_frame = 0, in_wait = 0, have_prev = 0, last_mode = 0, frame_mode = 0;
  bit exp_valid = 0, stuck_req = 0, stuck_active = 0;
  int rcnt = 0, hi_cnt = 0, wait_cnt = 0, conv_left = -1, exp_len = 16;
  int frames_done = 0, resyncs = 0, stops = 0;

  task start_frame(input bit m);
    in_frame   = 1;
    rcnt       = 0;
    cap_addr   = '0;
    out_sr     = stored_val;
    sdo        = out_sr[9];
    frame_mode = m;
    frame_chan = chan;
    exp_len    = m ? 16 : exp_len_f(int'(len));
    exp_valid  = have_prev && (m == last_mode);
    exp_data   = stored_val;
    exp_chan   = stored_chan;
  endtask

  always @(negedge clk) begin
    bit cs_fell, cs_rose, s_rise, s_fall, fe;
    cs_fell = cs_p && !cs_n;
    cs_rose = !cs_p && cs_n;
    s_rise  = !sc_p && sclk;
    s_fall  = sc_p && !sclk;
    fe = 0;
    if (!rst_n) begin
      in_frame = 0; in_wait = 0; have_prev = 0; last_mode = 0; conv_left = -1; eoc = 1;
    end else begin
      if (in_wait) wait_cnt++;
      if (sclk && !s_rise) hi_cnt++;
      if (in_frame && s_rise) begin
        rcnt++;
        hi_cnt = 1;
        if (rcnt <= 4) cap_addr = {cap_addr[2:0], addr};
      end
      if (in_frame && s_fall) begin
        if (rcnt == 1) check(hi_cnt == HALF_DIV, "R11", hi_cnt, HALF_DIV);
        if (rcnt < 10) begin
          out_sr = {out_sr[8:0], 1'b0};
          sdo = out_sr[9];
        end
      end
      if (in_frame && (cs_rose || (s_fall && rcnt == 16))) begin
        fe = 1;
        if (frame_mode) check(rcnt == exp_len, "R3", rcnt, exp_len);
        else            check(rcnt == exp_len, "R2", rcnt, exp_len);
        check(cap_addr == frame_chan, "R4", cap_addr, frame_chan);
        check(res_valid == exp_valid, "R7", res_valid, exp_valid);
        if (exp_valid && res_valid) begin
          check(res == exp_data, "R5", res, exp_data);
          check(res_chan == exp_chan, "R6", res_chan, exp_chan);
        end
        stored_val  = {cap_addr, seq};
        seq         = seq + 1'b1;
        stored_chan = frame_chan;
        have_prev   = 1;
        last_mode   = frame_mode;
        in_frame    = 0;
        frames_done++;
        if (!cs_n) begin
          eoc = 0;
          in_wait = 1;
          wait_cnt = 0;
          stuck_active = stuck_req;
          conv_left = stuck_req ? -1 : CONV;
          stuck_req = 0;
        end
      end
      if (res_valid && !fe) check(0, "R5", 1, 0);
      if (cs_rose && !fe && in_wait) begin
        in_wait = 0;
        if (cont) begin
          check(stuck_active, "R8", 0, 1);
          check(wait_cnt >= TIMEOUT_CYC && wait_cnt <= TIMEOUT_CYC + 2, "R8", wait_cnt, TIMEOUT_CYC);
          have_prev = 0;
          resyncs++;
          eoc = 1;
          conv_left = -1;
          stuck_active = 0;
        end else begin
          stops++;
        end
      end
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) begin
          conv_left = -1;
          eoc = 1;
          in_wait = 0;
          if (!cs_n) start_frame(1'b1);
        end
      end
      if (cs_fell) start_frame(cont);
    end
    cs_p = cs_n;
    sc_p = sclk;
  end

  task automatic wait_frames(input int n);
    int target = frames_done + n;
    while (frames_done < target) @(negedge clk);
  endtask

  task automatic run_rel(input logic [3:0] c, input logic [4:0] l);
    @(negedge clk);
    chan = c; len = l; start = 1;
    @(negedge clk);
    start = 0;
    wait_frames(1);
    repeat (HALF_DIV + 3) @(negedge clk);
  endtask

  initial begin
    repeat (HALF_DIV) @(posedge clk);
    n_fail++;
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int f0, r0, s0;
    n_fail = n_fail; // watchdog pre-count is removed below
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 during and just after reset
    check(cs_n == 1 && sclk == 0 && addr == 0 && res_valid == 0, "R1", {cs_n, sclk, addr, res_valid}, 4'b1000);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && addr == 0 && res_valid == 0, "R1", {cs_n, sclk, addr, res_valid}, 4'b1000);
    n_fail--; // cancel watchdog placeholder

    // released mode, directed lengths including clamps
    run_rel(4'd5, 5'd16);
    run_rel(4'd10, 5'd11);
    run_rel(4'd0, 5'd5);
    run_rel(4'd15, 5'd20);
    run_rel(4'd9, 5'd13);

    // R10: second start mid-frame is ignored
    f0 = frames_done;
    @(negedge clk); chan = 4'd6; len = 5'd12; start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chan = 4'd1; start = 1;
    @(negedge clk); start = 0; chan = 4'd6;
    wait_frames(1);
    repeat (4 * HALF_DIV) @(negedge clk);
    check(cs_n == 1, "R10", cs_n, 1);
    check(frames_done == f0 + 1, "R10", frames_done - f0, 1);

    // random released frames
    for (int i = 0; i < 20; i++) run_rel(4'($urandom_range(0, 13)), 5'($urandom_range(8, 20)));

    // continuous mode
    r0 = resyncs; s0 = stops;
    @(negedge clk); cont = 1; chan = 4'd3; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 10; i++) begin
      wait_frames(1);
      chan = 4'($urandom_range(0, 13));
    end
    check(resyncs == r0 && stops == s0, "R3", resyncs + stops, r0 + s0);

    // R8: one conversion never reports completion
    stuck_req = 1;
    while (resyncs == r0) @(negedge clk);
    check(resyncs == r0 + 1, "R8", resyncs - r0, 1);
    for (int i = 0; i < 3; i++) begin
      wait_frames(1);
      chan = 4'($urandom_range(0, 13));
    end

    // R9: leave continuous mode
    wait_frames(1);
    cont = 0;
    repeat (60) @(negedge clk);
    check(cs_n == 1, "R9", cs_n, 1);
    check(stops == s0 + 1, "R9", stops - s0, 1);

    run_rel(4'd7, 5'd13);
    run_rel(4'd8, 5'd16);
    run_rel(4'd12, 5'd14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule